// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Accumulator Processor

This block is a small accumulator machine. A register-transfer datapath holds a program counter, an instruction register, an operand register, an ALU result register, an accumulator and a one-bit zero flag. A sequencer walks every instruction through five fixed steps: fetch, count, operand read, execute and write-back. In each step it raises only the register enables and mux selects that the current opcode needs.

Two internal arrays hold the program and the data. Both are written through a load port. A read port brings the data array out once the machine has stopped. The machine runs from address zero after reset until it meets a halt instruction. It then raises `halted_o` and freezes until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `pc_o`, `acc_o` and `zero_o` are 0 and `halted_o` is 0. Asserting `rst_ni` low after a halt returns the machine to this state.
- R2: An instruction is 8 bits, with the opcode in bits 7:5 and the address in bits 4:0. Each non-halt instruction takes exactly 5 clocks. The PC advances by one (modulo 32) in the second step of every instruction.
- R3: The opcode encodings are 010 add, 011 and, and 100 xor. Each combines ACC with RAM[address] and writes the result to ACC. Add wraps modulo 256.
- R4: The zero flag becomes 1 exactly when the result of add, and, xor or load is 0x00. Skip, store and jump leave it unchanged.
- R5: Opcode 101 (load) copies RAM[address] into ACC. Opcode 110 (store) writes ACC into RAM[address].
- R6: Opcode 111 (jump) loads the address field into the PC.
- R7: Opcode 001 (skip if not zero) skips the next instruction when the zero flag is 0. When the flag is 1, the machine continues with the next instruction.
- R8: Opcode 000 (halt) sets `halted_o` three clocks after its fetch begins, leaving the PC at the halt address plus one. After that, PC, ACC and the zero flag stay unchanged until reset.
- R9: When `load_en_i` is high at a clock edge, `load_data_i` is written to `load_addr_i`. The target is the program array when `load_sel_i` is 0 and the data array when it is 1. While `halted_o` is 1, `rd_data_o` shows the data word at `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | Load port write strobe |
| load_sel_i | input | 1 | Load target: 0 program, 1 data |
| load_addr_i | input | 5 | Load port address |
| load_data_i | input | 8 | Load port write data |
| rd_addr_i | input | 5 | Data array read address, used while halted |
| rd_data_o | output | 8 | Data word at `rd_addr_i` while halted |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 5 | Program counter |
| zero_o | output | 1 | Zero flag |
| halted_o | output | 1 | Halt reached |

## Verification
The bench uses the default parameters: 5-bit addresses and 8-bit data. This makes both 32-word arrays fully loadable and readable, so every data word can be compared after each program.

The programs drive the adder through its carry-out wrap and steer the zero flag both set and clear ahead of the skip opcode. They also jump over a store and then halt. A bench-side instruction interpreter predicts the final ACC, PC, flag, data contents and the exact clock count for each run.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'd0,
    OP_SKNZ  = 3'd1,
    OP_ADD   = 3'd2,
    OP_AND   = 3'd3,
    OP_XOR   = 3'd4,
    OP_LOAD  = 3'd5,
    OP_STORE = 3'd6,
    OP_JUMP  = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_INC   = 3'd1,
    PH_OPER  = 3'd2,
    PH_EXEC  = 3'd3,
    PH_WB    = 3'd4,
    PH_HALT  = 3'd5
  } phase_e;

  typedef struct packed {
    logic ir_en;
    logic pc_en;
    logic pc_sel;   // 1: incremented PC, 0: address field
    logic mem_en;
    logic mem_sel;  // 1: data array, 0: ALU register
    logic alu_en;
    logic z_en;
    logic acc_en;
    logic ram_we;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_reg.sv
`timescale 1ns/1ps
module acc_cpu_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_cpu_mem.sv
`timescale 1ns/1ps
module acc_cpu_mem #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) arr_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = arr_q[raddr_i];
endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  opcode_e       op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opd_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] carry;
  logic [DW-1:0] sum;

  assign carry[0] = 1'b0;

  // ripple carry, final carry-out dropped
  for (genvar i = 0; i < DW; i++) begin : g_sum
    assign sum[i] = acc_i[i] ^ opd_i[i] ^ carry[i];
  end
  for (genvar i = 0; i < DW-1; i++) begin : g_carry
    assign carry[i+1] = (acc_i[i] & opd_i[i]) | (acc_i[i] & carry[i]) | (opd_i[i] & carry[i]);
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:   res_o = sum;
      OP_AND:   res_o = acc_i & opd_i;
      OP_XOR:   res_o = acc_i ^ opd_i;
      OP_LOAD:  res_o = opd_i;
      OP_STORE: res_o = acc_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  opcode_e op_i,
  input  logic    zero_i,
  output ctrl_t   ctl_o,
  output phase_e  phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    ctl_o   = '0;
    phase_d = phase_q;
    unique case (phase_q)
      PH_FETCH: begin
        ctl_o.ir_en = 1'b1;
        phase_d     = PH_INC;
      end
      PH_INC: begin
        ctl_o.pc_en  = 1'b1;
        ctl_o.pc_sel = 1'b1;
        phase_d      = PH_OPER;
      end
      PH_OPER: begin
        if (op_i == OP_HALT) begin
          phase_d = PH_HALT;
        end else begin
          ctl_o.mem_en  = 1'b1;
          ctl_o.mem_sel = 1'b1;
          phase_d       = PH_EXEC;
        end
      end
      PH_EXEC: begin
        ctl_o.alu_en = op_i inside {OP_ADD, OP_AND, OP_XOR, OP_LOAD, OP_STORE};
        ctl_o.z_en   = op_i inside {OP_ADD, OP_AND, OP_XOR, OP_LOAD};
        phase_d      = PH_WB;
      end
      PH_WB: begin
        unique case (op_i)
          OP_ADD, OP_AND, OP_XOR, OP_LOAD: ctl_o.acc_en = 1'b1;
          OP_STORE: begin
            ctl_o.mem_en  = 1'b1;
            ctl_o.mem_sel = 1'b0;
            ctl_o.ram_we  = 1'b1;
          end
          OP_JUMP: begin
            ctl_o.pc_en  = 1'b1;
            ctl_o.pc_sel = 1'b0;
          end
          OP_SKNZ: begin
            ctl_o.pc_en  = !zero_i;
            ctl_o.pc_sel = 1'b1;
          end
          default: ;
        endcase
        phase_d = PH_FETCH;
      end
      PH_HALT: phase_d = PH_HALT;
      default: phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_HALT |=> phase_q == PH_HALT); // R8
  AST_FETCH_THEN_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_FETCH |=> phase_q == PH_INC); // R2
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic          load_sel_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] pc_o,
  output logic          zero_o,
  output logic          halted_o
);
  ctrl_t         ctl;
  phase_e        phase;
  opcode_e       op;
  logic [AW-1:0] pc_q, pc_d, ir_addr, ram_raddr, ram_waddr;
  logic [DW-1:0] ir_q, acc_q, mem_q, mem_d, alu_q, alu_res;
  logic [DW-1:0] prog_rdata, ram_rdata, ram_wdata;
  logic [0:0]    zero_q, zero_d;
  logic          prog_we, ram_we;

  assign op      = opcode_e'(ir_q[DW-1 -: OP_W]);
  assign ir_addr = ir_q[AW-1:0];

  acc_cpu_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .zero_i (zero_q[0]),
    .ctl_o  (ctl),
    .phase_o(phase)
  );

  // program store
  assign prog_we = load_en_i && !load_sel_i;
  acc_cpu_mem #(.AW(AW), .DW(DW)) u_prog (
    .clk_i  (clk_i),
    .we_i   (prog_we),
    .waddr_i(load_addr_i),
    .wdata_i(load_data_i),
    .raddr_i(pc_q),
    .rdata_o(prog_rdata)
  );

  // data RAM; load port wins over a store
  assign ram_we    = (load_en_i && load_sel_i) || ctl.ram_we;
  assign ram_waddr = (load_en_i && load_sel_i) ? load_addr_i : ir_addr;
  assign ram_wdata = (load_en_i && load_sel_i) ? load_data_i : alu_q;
  assign ram_raddr = halted_o ? rd_addr_i : ir_addr;
  acc_cpu_mem #(.AW(AW), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(ram_wdata),
    .raddr_i(ram_raddr),
    .rdata_o(ram_rdata)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op_i (op),
    .acc_i(acc_q),
    .opd_i(mem_q),
    .res_o(alu_res)
  );

  assign pc_d   = ctl.pc_sel ? pc_q + AW'(1) : ir_addr;
  assign mem_d  = ctl.mem_sel ? ram_rdata : alu_q;
  assign zero_d = (alu_res == '0) ? 1'b1 : 1'b0;

  acc_cpu_reg #(.W(AW)) u_pc   (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.pc_en),  .d_i(pc_d),       .q_o(pc_q));
  acc_cpu_reg #(.W(DW)) u_ir   (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.ir_en),  .d_i(prog_rdata), .q_o(ir_q));
  acc_cpu_reg #(.W(DW)) u_mem  (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.mem_en), .d_i(mem_d),      .q_o(mem_q));
  acc_cpu_reg #(.W(DW)) u_aluq (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.alu_en), .d_i(alu_res),    .q_o(alu_q));
  acc_cpu_reg #(.W(1))  u_zero (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.z_en),   .d_i(zero_d),     .q_o(zero_q));
  acc_cpu_reg #(.W(DW)) u_acc  (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.acc_en), .d_i(alu_q),      .q_o(acc_q));

  assign acc_o     = acc_q;
  assign pc_o      = pc_q;
  assign zero_o    = zero_q[0];
  assign halted_o  = (phase == PH_HALT);
  assign rd_data_o = ram_rdata;

  AST_PC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_INC |=> pc_q == $past(pc_q) + AW'(1)); // R2
  AST_ADD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_EXEC && op == OP_ADD) |=> alu_q == DW'($past(acc_q) + $past(mem_q))); // R3
  AST_ZERO_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.z_en |=> zero_q[0] == (alu_q == '0)); // R4
  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != PH_EXEC |=> $stable(zero_q)); // R4
  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WB && op == OP_JUMP) |=> pc_q == $past(ir_addr)); // R6
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(pc_q) && $stable(acc_q) && $stable(zero_q)); // R8
endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_en_i = 1'b0;
  logic          load_sel_i = 1'b0;
  logic [AW-1:0] load_addr_i = '0;
  logic [DW-1:0] load_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o, acc_o;
  logic [AW-1:0] pc_o;
  logic          zero_o, halted_o;

  acc_cpu #(.AW(AW), .DW(DW)) u0 (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] p_img [DEPTH];
  logic [DW-1:0] d_img [DEPTH];
  logic [DW-1:0] e_ram [DEPTH];
  logic [DW-1:0] e_acc;
  logic [AW-1:0] e_pc;
  logic          e_z;
  int            e_cyc;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input int op, input int a);
    return {3'(op), 5'(a)};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) begin
      p_img[i] = '0;
      d_img[i] = '0;
    end
  endtask

  // instruction-level reference interpreter
  task automatic ref_run();
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] acc = '0;
    logic [DW-1:0] ir;
    logic z = 1'b0;
    int cyc = 0;
    for (int i = 0; i < DEPTH; i++) e_ram[i] = d_img[i];
    for (int s = 0; s < 300; s++) begin
      ir = p_img[pc];
      pc = pc + 1'b1;
      if (ir[7:5] == 3'd0) begin
        cyc += 3;
        break;
      end
      cyc += 5;
      case (ir[7:5])
        3'd1: if (!z) pc = pc + 1'b1;
        3'd2: begin acc = acc + e_ram[ir[4:0]]; z = (acc == 0); end
        3'd3: begin acc = acc & e_ram[ir[4:0]]; z = (acc == 0); end
        3'd4: begin acc = acc ^ e_ram[ir[4:0]]; z = (acc == 0); end
        3'd5: begin acc = e_ram[ir[4:0]];       z = (acc == 0); end
        3'd6: e_ram[ir[4:0]] = acc;
        default: pc = ir[4:0];
      endcase
    end
    e_acc = acc; e_pc = pc; e_z = z; e_cyc = cyc;
  endtask

  // R9: images written through the load port while held in reset
  task automatic load_and_run(input string name);
    int cyc = 0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      load_en_i   = 1'b1;
      load_sel_i  = (i >= DEPTH);
      load_addr_i = AW'(i % DEPTH);
      load_data_i = (i >= DEPTH) ? d_img[i % DEPTH] : p_img[i % DEPTH];
      @(negedge clk_i);
    end
    load_en_i = 1'b0;
    ref_run();
    rst_ni = 1'b1;
    while (!halted_o && cyc < 2000) begin
      @(negedge clk_i);
      cyc++;
    end
    check(halted_o, {name, " R8 halted"}, halted_o, 1);
    check(cyc == e_cyc, {name, " R2 clock count"}, cyc, e_cyc);
    check(pc_o == e_pc, {name, " R8 final pc"}, pc_o, e_pc);
    check(acc_o == e_acc, {name, " R3 R5 acc"}, acc_o, e_acc);
    check(zero_o == e_z, {name, " R4 zero flag"}, zero_o, e_z);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr_i = AW'(i);
      #1;
      check(rd_data_o == e_ram[i], {name, " R5 R9 data word"}, rd_data_o, e_ram[i]);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    check(pc_o == 0 && acc_o == 0, "R1 pc/acc in reset", {pc_o, acc_o}, 0);
    check(!zero_o && !halted_o, "R1 flags in reset", {zero_o, halted_o}, 0);
  endtask

  task automatic t_arith();
    clear_img();
    d_img[1] = 8'hF0; d_img[2] = 8'h25; d_img[3] = 8'h3C; d_img[4] = 8'h5A;
    p_img[0] = ins(5, 1);   // acc = F0
    p_img[1] = ins(2, 2);   // wraps to 15
    p_img[2] = ins(3, 3);
    p_img[3] = ins(4, 4);
    p_img[4] = ins(6, 5);
    p_img[5] = ins(0, 0);
    load_and_run("arith");
    check(acc_o == 8'h4E, "R3 add wrap/and/xor result", acc_o, 8'h4E);
  endtask

  task automatic t_skip();
    clear_img();
    d_img[1] = 8'h00; d_img[2] = 8'h77; d_img[10] = 8'hEE; d_img[11] = 8'hEE;
    p_img[0] = ins(5, 1);   // z=1
    p_img[1] = ins(1, 0);   // no skip
    p_img[2] = ins(6, 10);
    p_img[3] = ins(5, 2);   // z=0
    p_img[4] = ins(1, 0);   // skip next
    p_img[5] = ins(6, 11);
    p_img[6] = ins(6, 12);
    p_img[7] = ins(3, 1);   // z=1
    p_img[8] = ins(6, 13);  // store keeps z
    p_img[9] = ins(0, 0);
    load_and_run("skip");
    rd_addr_i = 5'd10; #1;
    check(rd_data_o == 8'h00, "R7 no skip when zero set", rd_data_o, 0);
    rd_addr_i = 5'd11; #1;
    check(rd_data_o == 8'hEE, "R7 skipped store", rd_data_o, 8'hEE);
    check(zero_o == 1'b1, "R4 flag kept across store", zero_o, 1);
  endtask

  task automatic t_jump();
    clear_img();
    d_img[1] = 8'h81; d_img[2] = 8'h81; d_img[6] = 8'h11;
    p_img[0] = ins(5, 1);
    p_img[1] = ins(7, 4);   // over store
    p_img[2] = ins(6, 6);
    p_img[3] = ins(0, 0);
    p_img[4] = ins(4, 2);
    p_img[5] = ins(6, 7);
    p_img[6] = ins(7, 3);
    load_and_run("jump");
    check(pc_o == 5'd4, "R6 jump back to halt", pc_o, 4);
    rd_addr_i = 5'd6; #1;
    check(rd_data_o == 8'h11, "R6 jumped-over store", rd_data_o, 8'h11);
  endtask

  task automatic t_freeze_and_reset();
    logic [DW-1:0] acc_s = acc_o;
    logic [AW-1:0] pc_s  = pc_o;
    logic          z_s   = zero_o;
    repeat (20) @(negedge clk_i);
    check(acc_o == acc_s && pc_o == pc_s && zero_o == z_s, "R8 frozen after halt",
          {acc_o, pc_o}, {acc_s, pc_s});
    check(halted_o, "R8 halt held", halted_o, 1);
    rst_ni = 1'b0;
    #1;
    check(pc_o == 0 && acc_o == 0 && !zero_o && !halted_o, "R1 reset after halt",
          {pc_o, acc_o, zero_o, halted_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(pc_o == 0 && !halted_o, "R1 first clock after reset", {pc_o, halted_o}, 0);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_skip();
    t_jump();
    t_freeze_and_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule